// File: doc/BRIEF.md
# Two-Channel Offset Calibration Sequencer

This block sits in the sample path of a stereo audio converter, just before the serial output formatter. An active-low reset holds it idle. When reset is released it runs a calibration cycle timed in frame ticks. A frame tick is a one-clock strobe that marks each frame, and each tick carries one new 24-bit two's complement sample per channel. During the final 256 frames of the cycle it adds up each channel's samples. It divides each total by 256 and keeps the result as that channel's offset. From then on it subtracts the stored offset from every sample and clamps the result to 24 bits.

A busy flag stays high from the moment reset falls until the calibration window has closed. A source-select output tells the analog front end what to measure during calibration: either the common-mode reference or the live inputs. The cycle is one frame longer when the converter runs as a frame-clock slave.

The controller has three named states. ST_CAL counts frames with busy high. It moves to ST_SETTLE on the tick that closes the calibration window. ST_SETTLE counts further frames with busy low and the output still muted. It moves to ST_RUN on the tick that reaches the data-valid count. ST_RUN passes corrected samples out. Reset, at any time, forces ST_CAL with a zero frame count.

Top module: `ocal_seq`

## Requirements
- R1: While rst_n is low, cal_busy is 1, out_valid is 0 and both output samples are zero.
- R2: With slave_mode=0, cal_busy is still 1 after the 8703rd frame tick following reset release, and is 0 in the clock after the 8704th. It stays 0 until the next reset.
- R3: With slave_mode=1, both the busy count and the data-valid count are one frame longer: busy falls after the 8705th tick and data becomes valid after the 8961st.
- R4: While cal_busy is 1, src_sel equals zcal_sel (0 = common-mode reference, 1 = channel's live inputs). While cal_busy is 0, src_sel is 1.
- R5: Each channel's offset is the arithmetic right shift by 8 of the signed sum of that channel's samples from the last 256 ticks of the busy period, counting the tick that ends it.
- R6: out_valid stays 0 and both outputs stay zero up to and including the data-valid tick (8960 master, 8961 slave).
- R7: For every tick after the data-valid tick, out_valid is 1 in the following clock only. Each output then equals that tick's input minus its channel's offset.
- R8: A difference above 7FFFFF hex is output as 7FFFFF. A difference below -800000 hex is output as 800000.
- R9: A new reset release restarts the whole cycle and replaces both offsets, including when reset falls in the middle of a cycle.
- R10: Samples presented before the 256-tick window have no effect on the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; its rising edge starts a calibration cycle |
| frame_tick | input | 1 | One-clock strobe per frame; qualifies in_left/in_right |
| slave_mode | input | 1 | 1 when the frame clock is received rather than generated |
| zcal_sel | input | 1 | Calibration source choice: 0 common-mode, 1 live inputs |
| in_left | input | 24 | Left channel sample, two's complement |
| in_right | input | 24 | Right channel sample, two's complement |
| cal_busy | output | 1 | High during reset and the calibration cycle |
| src_sel | output | 1 | Source select driven to the analog front end |
| out_valid | output | 1 | One-clock strobe for a corrected output pair |
| out_left | output | 24 | Corrected left sample |
| out_right | output | 24 | Corrected right sample |

## Verification
Some properties are checked on every cycle. The busy flag never rises again without a reset, and it only ever falls in the clock after a frame tick. Output strobes follow a tick and never appear while busy, and the outputs read zero for as long as busy is high. Other behaviour can only be shown by the bench's scenarios. These are the exact frame counts in both modes, the offset arithmetic over the 256-tick window, the exclusion of early samples, clamping at both rails, and the restart after a reset that interrupts a cycle.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
    typedef enum logic [1:0] {
        ST_CAL    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_RUN    = 2'd2
    } ocal_state_e;
endpackage

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
    import ocal_pkg::*;
#(
    parameter int CAL_FRAMES   = 8704,
    parameter int VALID_FRAMES = 8960,
    parameter int WIN_LOG2     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_tick,
    input  logic        slave_mode,
    output ocal_state_e state,
    output logic        win_add,
    output logic        win_last
);
    localparam int CW  = $clog2(VALID_FRAMES + 2);
    localparam int WIN = 1 << WIN_LOG2;

    ocal_state_e    nxt;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  cal_len;
    logic [CW-1:0]  val_len;
    logic           cal_end;
    logic           val_end;

    // slave mode stretches both counts by one frame
    assign cal_len = CW'(CAL_FRAMES) + CW'(slave_mode);
    assign val_len = CW'(VALID_FRAMES) + CW'(slave_mode);
    assign cal_end = frame_tick && (cnt == cal_len - CW'(1));
    assign val_end = frame_tick && (cnt == val_len - CW'(1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CAL:    if (cal_end) nxt = ST_SETTLE;
            ST_SETTLE: if (val_end) nxt = ST_RUN;
            ST_RUN:    nxt = ST_RUN;
            default:   nxt = ST_CAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CAL;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cnt <= '0;
        else if (frame_tick && state != ST_RUN) cnt <= cnt + CW'(1);
    end

    assign win_add  = (state == ST_CAL) && frame_tick && (cnt >= cal_len - CW'(WIN));
    assign win_last = (state == ST_CAL) && cal_end;
endmodule

// File: rtl/ocal_chan_acc.sv
module ocal_chan_acc #(
    parameter int DW       = 24,
    parameter int AW       = 32,
    parameter int WIN_LOG2 = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          add_en,
    input  logic          add_last,
    input  logic [DW-1:0] sample,
    output logic [DW-1:0] offset
);
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] acc_sum;

    assign acc_sum = acc + $signed({{(AW-DW){sample[DW-1]}}, sample});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            offset <= '0;
        end else if (add_en) begin
            if (add_last) begin
                offset <= DW'(acc_sum >>> WIN_LOG2);
                acc    <= '0;
            end else begin
                acc    <= acc_sum;
            end
        end
    end
endmodule

// File: rtl/ocal_sat_sub.sv
module ocal_sat_sub #(
    parameter int DW = 24
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y
);
    logic [DW:0] d;

    always_comb begin
        d = {a[DW-1], a} - {b[DW-1], b};
        if (d[DW] != d[DW-1])
            y = d[DW] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        else
            y = d[DW-1:0];
    end
endmodule

// File: rtl/ocal_seq.sv
module ocal_seq
    import ocal_pkg::*;
#(
    parameter int DW           = 24,
    parameter int AW           = 32,
    parameter int CAL_FRAMES   = 8704,
    parameter int VALID_FRAMES = 8960,
    parameter int WIN_LOG2     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_tick,
    input  logic          slave_mode,
    input  logic          zcal_sel,
    input  logic [DW-1:0] in_left,
    input  logic [DW-1:0] in_right,
    output logic          cal_busy,
    output logic          src_sel,
    output logic          out_valid,
    output logic [DW-1:0] out_left,
    output logic [DW-1:0] out_right
);
    localparam int NCH = 2;

    ocal_state_e   state;
    logic          win_add;
    logic          win_last;
    logic [DW-1:0] smp  [NCH];
    logic [DW-1:0] offs [NCH];
    logic [DW-1:0] diff [NCH];
    logic [DW-1:0] oreg [NCH];

    assign smp[0] = in_left;
    assign smp[1] = in_right;

    ocal_ctrl #(
        .CAL_FRAMES  (CAL_FRAMES),
        .VALID_FRAMES(VALID_FRAMES),
        .WIN_LOG2    (WIN_LOG2)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_tick(frame_tick),
        .slave_mode(slave_mode),
        .state     (state),
        .win_add   (win_add),
        .win_last  (win_last)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ocal_chan_acc #(.DW(DW), .AW(AW), .WIN_LOG2(WIN_LOG2)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_en  (win_add),
            .add_last(win_last),
            .sample  (smp[c]),
            .offset  (offs[c])
        );
        ocal_sat_sub #(.DW(DW)) u_sub (
            .a(smp[c]),
            .b(offs[c]),
            .y(diff[c])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            for (int c = 0; c < NCH; c++) oreg[c] <= '0;
        end else begin
            out_valid <= (state == ST_RUN) && frame_tick;
            if ((state == ST_RUN) && frame_tick)
                for (int c = 0; c < NCH; c++) oreg[c] <= diff[c];
        end
    end

    assign cal_busy  = (state == ST_CAL);
    assign src_sel   = cal_busy ? zcal_sel : 1'b1;
    assign out_left  = oreg[0];
    assign out_right = oreg[1];
endmodule

// File: rtl/ocal_seq_chk.sv
module ocal_seq_chk #(
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_tick,
    input logic          cal_busy,
    input logic          out_valid,
    input logic [DW-1:0] out_left,
    input logic [DW-1:0] out_right
);
    assert_busy_stays_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_busy |=> !cal_busy);

    assert_busy_falls_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cal_busy) |-> $past(frame_tick));

    assert_no_valid_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cal_busy);

    assert_muted_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy |-> (out_left == '0 && out_right == '0));

    assert_valid_follows_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(frame_tick));
endmodule

bind ocal_seq ocal_seq_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_tick(frame_tick),
    .cal_busy  (cal_busy),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/sim_ocal_seq.sv
module sim_ocal_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic        slave_mode = 1'b0;
    logic        zcal_sel = 1'b0;
    logic [23:0] in_left = '0;
    logic [23:0] in_right = '0;
    logic        cal_busy, src_sel, out_valid;
    logic [23:0] out_left, out_right;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ocal_seq u0 (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .slave_mode(slave_mode),
        .zcal_sel(zcal_sel), .in_left(in_left), .in_right(in_right),
        .cal_busy(cal_busy), .src_sel(src_sel), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [23:0] ref_out(input logic [23:0] x, input longint off);
        longint d = sx(x) - off;
        if (d > 64'sd8388607)  d = 64'sd8388607;
        if (d < -64'sd8388608) d = -64'sd8388608;
        return d[23:0];
    endfunction

    function automatic bool_sat(input logic [23:0] x, input longint off);
        longint d = sx(x) - off;
        return (d > 64'sd8388607) || (d < -64'sd8388608);
    endfunction

    task automatic send(input logic [23:0] l, input logic [23:0] r);
        repeat (3) @(negedge clk);
        in_left = l;
        in_right = r;
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic hold_reset(input bit zc);
        @(negedge clk);
        rst_n = 1'b0;
        zcal_sel = zc;
        repeat (3) @(negedge clk);
        chk(cal_busy == 1'b1, "R1 busy", cal_busy, 1);
        chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
        chk(out_left == 24'h0 && out_right == 24'h0, "R1 data", out_left, 0);
        chk(src_sel == zc, "R4 sel in reset", src_sel, zc);
        zcal_sel = ~zc;
        @(negedge clk);
        chk(src_sel == ~zc, "R4 sel follows", src_sel, ~zc);
        zcal_sel = zc;
        @(negedge clk);
    endtask

    task automatic run_cycle(input bit slave, input bit zc, input int centre_l, input int centre_r);
        int cal_len = 8704 + int'(slave);
        int val_len = 8960 + int'(slave);
        longint sum_l = 0;
        longint sum_r = 0;
        longint off_l, off_r;
        logic [23:0] l, r, el, er;
        string tag;
        slave_mode = slave;
        hold_reset(zc);
        rst_n = 1'b1;
        for (int k = 1; k <= val_len; k++) begin
            if (k > cal_len - 256 && k <= cal_len) begin
                l = 24'(centre_l + int'($urandom % 4096) - 2048);
                r = 24'(centre_r + int'($urandom % 4096) - 2048);
                sum_l += sx(l);
                sum_r += sx(r);
            end else begin
                // early and late samples are large garbage (R10)
                l = 24'($urandom);
                r = 24'($urandom);
            end
            send(l, r);
            if (k == cal_len - 1) begin
                chk(cal_busy == 1'b1, slave ? "R3 busy held" : "R2 busy held", cal_busy, 1);
                chk(src_sel == zc, "R4 sel during cal", src_sel, zc);
            end
            if (k == cal_len) begin
                chk(cal_busy == 1'b0, slave ? "R3 busy fell" : "R2 busy fell", cal_busy, 0);
                chk(src_sel == 1'b1, "R4 sel after cal", src_sel, 1);
                chk(out_valid == 1'b0 && out_left == 24'h0, "R6 muted", out_left, 0);
            end
            if (k == val_len) begin
                chk(out_valid == 1'b0, slave ? "R3 not yet valid" : "R6 not yet valid", out_valid, 0);
                chk(out_left == 24'h0 && out_right == 24'h0, "R6 zero data", out_right, 0);
            end
        end
        off_l = sum_l >>> 8;
        off_r = sum_r >>> 8;
        for (int j = 0; j < 24; j++) begin
            unique case (j)
                0: begin l = 24'h7FFFFF; r = 24'h800000; end
                1: begin l = 24'h800000; r = 24'h7FFFFF; end
                2: begin l = 24'h000000; r = 24'h000001; end
                default: begin l = 24'($urandom); r = 24'($urandom); end
            endcase
            send(l, r);
            el = ref_out(l, off_l);
            er = ref_out(r, off_r);
            chk(out_valid == 1'b1, "R7 strobe", out_valid, 1);
            tag = bool_sat(l, off_l) ? "R8 left clamp" : "R5 R7 left";
            chk(out_left == el, tag, out_left, el);
            tag = bool_sat(r, off_r) ? "R8 right clamp" : "R5 R7 right";
            chk(out_right == er, tag, out_right, er);
            @(negedge clk);
            chk(out_valid == 1'b0, "R7 one clock", out_valid, 0);
            chk(cal_busy == 1'b0, "R2 stays low", cal_busy, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd1237));
        // master, live inputs, positive offset so 800000 inputs clamp
        run_cycle(1'b0, 1'b1, 3145728, -1000);
        // interrupted cycle: a reset mid-way restarts (R9)
        hold_reset(1'b0);
        rst_n = 1'b1;
        for (int k = 0; k < 60; k++) send(24'($urandom), 24'($urandom));
        chk(cal_busy == 1'b1, "R9 still calibrating", cal_busy, 1);
        // slave, common-mode source, negative offset so 7FFFFF inputs clamp
        run_cycle(1'b1, 1'b0, -4194304, 2500000);
        // master again, near-zero offsets replace the old ones (R9)
        run_cycle(1'b0, 1'b0, 100, -100);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule